// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small programmable logic device. A sum-of-products data term, after an optional inversion, either goes straight to the output or feeds a storage element. That storage element can act as a D, T or JK flip-flop. The register is clocked by either a global clock or a dedicated product-term clock. Product-term preset and clear inputs act on it asynchronously.

A host controller can also write the register over its parallel bus, with a load strobe and a data bit. It reads the cell value back through the same output that feeds the logic array. A product-term output enable decides whether the cell drives its pin.

All modes come from a static 5-bit configuration word:

| Bits | Field | Encoding |
|------|-------|----------|
| `[1:0]` | flip-flop type | 00 = D, 01 = T, 10 = JK, 11 = D |
| `[2]` | clock select | 1 = global clock, 0 = product-term clock |
| `[3]` | polarity | 1 = invert the data term |
| `[4]` | output path | 1 = registered, 0 = combinational |

The AND array, term allocation and pin buffers sit outside the block. Their signals arrive as plain inputs.

Top module: `pld_out_cell`

## Requirements
- R1: In D mode (cfg[1:0] = 00 or 11), the register takes the polarity-adjusted data term d at each rising edge of the selected clock.
- R2: In T mode (cfg[1:0] = 01), the register inverts at a selected-clock edge when d = 1 and holds when d = 0.
- R3: In JK mode (cfg[1:0] = 10), J is d and K is `pt_k`. The pair {J,K} = 00 holds, 01 clears, 10 sets and 11 toggles.
- R4: The data term is d = `sop` XOR cfg[3], so cfg[3] = 1 inverts the sum-of-products before any use.
- R5: cfg[2] = 1 clocks the register from `gclk` and cfg[2] = 0 from `ptclk`. Edges of the clock not selected leave the register unchanged.
- R6: `pt_clr` forces the register to 0 and `pt_pre` forces it to 1, both at once without waiting for a clock edge. When both are high, clear wins.
- R7: A high `host_ld` at a selected-clock edge loads `host_d` in place of the flip-flop update. An active preset or clear overrides the host load.
- R8: `cell_val` carries the register Q when cfg[4] = 1 and d when cfg[4] = 0. It serves as both array feedback and host readback.
- R9: `pin_oe` follows `pt_oe`. `pin_out` equals `cell_val` while `pt_oe` = 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk | input | 1 | Global clock |
| ptclk | input | 1 | Product-term clock |
| cfg | input | 5 | Static mode word (bit fields listed above) |
| sop | input | 1 | Sum-of-products data term |
| pt_k | input | 1 | Second term, used as K in JK mode |
| pt_pre | input | 1 | Asynchronous preset term |
| pt_clr | input | 1 | Asynchronous clear term |
| pt_oe | input | 1 | Output-enable term |
| host_ld | input | 1 | Host load strobe |
| host_d | input | 1 | Host data bit |
| cell_val | output | 1 | Cell value, used for feedback and readback |
| pin_out | output | 1 | Gated value toward the pin |
| pin_oe | output | 1 | Pin drive enable |

## Verification
A wrong next-state choice in registered mode shows on `cell_val` one selected-clock edge after the offending inputs. It never takes longer, because the register drives the output directly. A mis-ordered preset, clear or host-load priority shows in the same cycle for the asynchronous terms, and one edge later for the load. A wrong clock choice shows as a change, or no change, on the clock edge that should have had the opposite effect. A fault in the polarity or output-path select shows on `cell_val` straight away in combinational mode.

// File: rtl/pld_out_cell.sv
module pld_out_cell (
  input  logic       gclk,
  input  logic       ptclk,
  input  logic [4:0] cfg,
  input  logic       sop,
  input  logic       pt_k,
  input  logic       pt_pre,
  input  logic       pt_clr,
  input  logic       pt_oe,
  input  logic       host_ld,
  input  logic       host_d,
  output logic       cell_val,
  output logic       pin_out,
  output logic       pin_oe
);
  localparam logic [1:0] TY_T  = 2'b01;
  localparam logic [1:0] TY_JK = 2'b10;

  logic mclk, d, q, nxt;

  assign mclk = cfg[2] ? gclk : ptclk;
  assign d    = sop ^ cfg[3];

  always_comb begin
    case (cfg[1:0])
      TY_T:    nxt = q ^ d;
      TY_JK:   case ({d, pt_k})
                 2'b00:   nxt = q;
                 2'b01:   nxt = 1'b0;
                 2'b10:   nxt = 1'b1;
                 default: nxt = ~q;
               endcase
      default: nxt = d;
    endcase
  end

  always_ff @(posedge mclk or posedge pt_clr or posedge pt_pre) begin
    if (pt_clr)       q <= 1'b0;
    else if (pt_pre)  q <= 1'b1;
    else if (host_ld) q <= host_d;
    else              q <= nxt;
  end

  assign cell_val = cfg[4] ? q : d;
  assign pin_oe   = pt_oe;
  assign pin_out  = pt_oe & cell_val;
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk (
  input logic       gclk,
  input logic [4:0] cfg,
  input logic       sop,
  input logic       pt_pre,
  input logic       pt_clr,
  input logic       pt_oe,
  input logic       host_ld,
  input logic       host_d,
  input logic       cell_val,
  input logic       pin_out
);
  logic started = 1'b0;
  always_ff @(posedge gclk) started <= 1'b1;

  logic steady;
  assign steady = cfg[2] && cfg[4] && !pt_clr && !pt_pre;

  // R9
  oe_gate_chk: assert property (@(posedge gclk) disable iff (!started)
    !pt_oe |-> !pin_out);

  // R6
  clr_wins_chk: assert property (@(posedge gclk) disable iff (!started)
    (pt_clr && cfg[4]) |-> !cell_val);

  // R6
  pre_set_chk: assert property (@(posedge gclk) disable iff (!started)
    (pt_pre && !pt_clr && cfg[4]) |-> cell_val);

  // R7
  host_ld_chk: assert property (@(posedge gclk) disable iff (!started)
    (steady && host_ld) |=> (!steady || cell_val == $past(host_d)));

  // R1
  d_mode_chk: assert property (@(posedge gclk) disable iff (!started)
    (steady && !host_ld && cfg[1:0] == 2'b00) |=>
      (!steady || cell_val == $past(sop ^ cfg[3])));

  // R2
  t_mode_chk: assert property (@(posedge gclk) disable iff (!started)
    (steady && !host_ld && cfg[1:0] == 2'b01) |=>
      (!steady || cell_val == ($past(cell_val) ^ $past(sop ^ cfg[3]))));
endmodule

bind pld_out_cell pld_out_cell_chk u_chk (
  .gclk(gclk), .cfg(cfg), .sop(sop), .pt_pre(pt_pre), .pt_clr(pt_clr),
  .pt_oe(pt_oe), .host_ld(host_ld), .host_d(host_d),
  .cell_val(cell_val), .pin_out(pin_out)
);

// File: tb/sim_pld_out_cell.sv
module sim_pld_out_cell;
  logic gclk = 1'b0, ptclk = 1'b0;
  logic [4:0] cfg = 5'b10100;
  logic sop = 0, pt_k = 0, pt_pre = 0, pt_clr = 0, pt_oe = 1, host_ld = 0, host_d = 0;
  logic cell_val, pin_out, pin_oe;
  int checks = 0, fails = 0;

  always #4 gclk = ~gclk;

  pld_out_cell u0 (.*);

  // {type[1:0], inv, sop, k, init, exp}
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    7'b00_0_1_0_0_1, 7'b00_0_0_0_1_0, 7'b00_1_1_0_0_0, 7'b00_1_0_0_0_1,
    7'b01_0_1_0_0_1, 7'b01_0_1_0_1_0, 7'b01_0_0_0_1_1, 7'b01_1_1_0_1_1,
    7'b10_0_0_0_1_1, 7'b10_0_0_1_1_0, 7'b10_0_1_0_0_1, 7'b10_0_1_1_0_1,
    7'b10_0_1_1_1_0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // reset state via clear term (R6)
    @(negedge gclk); pt_clr = 1;
    #1 chk("R6 clear", cell_val, 1'b0);
    @(negedge gclk); pt_clr = 0;

    // R1 R2 R3 R4 vector walk on the global clock
    for (int i = 0; i < NV; i++) begin
      @(negedge gclk);
      cfg = {1'b1, VEC[i][4], 1'b1, VEC[i][6:5]};
      host_ld = 1; host_d = VEC[i][1];
      @(negedge gclk);
      host_ld = 0; sop = VEC[i][3]; pt_k = VEC[i][2];
      @(negedge gclk);
      chk(VEC[i][6:5] == 2'b00 ? "R1/R4 D" : VEC[i][6:5] == 2'b01 ? "R2 T" : "R3 JK",
          cell_val, VEC[i][0]);
    end
    pt_k = 0;

    // R6 asynchronous preset, then clear beats preset
    cfg = 5'b10100; sop = 0;
    @(negedge gclk); #1 pt_pre = 1;
    #1 chk("R6 preset", cell_val, 1'b1);
    pt_clr = 1;
    #1 chk("R6 clear wins", cell_val, 1'b0);
    pt_clr = 0; pt_pre = 0;

    // R7 host load beats clocked update
    @(negedge gclk); sop = 1; host_ld = 1; host_d = 0;
    @(negedge gclk); host_ld = 0;
    chk("R7 load over update", cell_val, 1'b0);
    // R7 preset beats host load
    pt_pre = 1; host_ld = 1; host_d = 0;
    @(negedge gclk); chk("R7 preset over load", cell_val, 1'b1);
    pt_pre = 0; host_ld = 0;

    // R8 combinational path follows d, with polarity (R4)
    @(negedge gclk); cfg = 5'b00000; sop = 1;
    #1 chk("R8 comb", cell_val, 1'b1);
    cfg = 5'b01000;
    #1 chk("R8/R4 comb inverted", cell_val, 1'b0);

    // R5 product-term clock selected: gclk edges ignored
    cfg = 5'b10000; pt_clr = 1; #1 pt_clr = 0; sop = 1;
    @(negedge gclk); @(negedge gclk);
    chk("R5 gclk ignored", cell_val, 1'b0);
    #1 ptclk = 1; #1 ptclk = 0;
    #1 chk("R5 ptclk edge", cell_val, 1'b1);

    // R9 output enable gating
    @(negedge gclk); cfg = 5'b10100; pt_oe = 0;
    #1 chk("R9 pin off", pin_out, 1'b0);
    chk("R9 oe low", pin_oe, 1'b0);
    pt_oe = 1;
    #1 chk("R9 pin on", pin_out, cell_val);
    chk("R9 oe high", pin_oe, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule